// File: doc/BRIEF.md
# Serial Transport Overhead Insertion Port

This block runs next to the transmit overhead processor of an STS-3 framer. External logic can use it to overwrite transport overhead bytes one bit at a time. The block drives a slow port clock, which it divides down from the system clock. On that clock it also drives a one-cycle frame marker and an enable strobe that is high during every overhead bit slot. The external logic watches the marker and the strobe on the rising edge of the port clock. It then presents a data bit and an insert request, and the block captures both on the falling edge.

Captured bits are shifted in MSB first and assembled into bytes. Each finished byte leaves the block as a one-cycle result. The result carries its row, its column and its tributary index, and a flag that tells whether the external value won. When the external value does not win, the processor's own byte, supplied on `int_byte_i`, passes through instead. A per-bit acceptance rule picks the winner. It is stricter for the orderwire, user-channel and data-communication bytes than for all other overhead bytes.

Top module: `toh_insert_port`

## Requirements
- R1: `tx_oh_clk_o` is a square wave with HALF_DIV system clocks per phase. `tx_oh_strobe_o` and `tx_oh_frame_o` change only in the system cycle where `tx_oh_clk_o` rises.
- R2: A frame has 1944 consecutive port cycles with the strobe high (243 bytes of 8 bits), then IDLE_SLOTS port cycles with the strobe low. `tx_oh_frame_o` is high for exactly the first strobe cycle of each frame.
- R3: Bytes are walked row by row (rows 0..8). Within a row the walk goes column by column (0..8), and within a column by tributary (0..2), with the tributary changing fastest. Reported positions stay within those ranges.
- R4: Data and insert request are sampled at the falling edge of the port clock, first bit = byte bit 7. `oh_valid_o` is high for one system cycle after the falling edge that takes the eighth bit.
- R5: Restricted bytes are all of row 1 with column 3 or higher, all of rows 2, 5, 6 and 7, and row 8 with column 6 or higher. A bit of a restricted byte is accepted only when `tx_oh_ins_i` is high.
- R6: A bit of any other byte is accepted when `tx_oh_ins_i` is high, or when both `tx_oh_ins_i` and `sw_ins_en_i` are low.
- R7: With `tx_oh_ins_i` low and `sw_ins_en_i` high, the serial data is ignored and the byte reports `oh_ext_o` low.
- R8: A byte with any bit not accepted is not overridden. `oh_ext_o` is low and `oh_byte_o` equals `int_byte_i`.
- R9: With `oh_valid_o` high, `oh_byte_o` is the assembled serial byte when `oh_ext_o` is high, and otherwise `int_byte_i` in the same cycle.
- R10: While `rst_ni` is low, the port clock, strobe, frame marker and valid are low. After release, the first rising port edge starts a new frame at row 0, column 0, tributary 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_ins_en_i | input | 1 | Software insertion enable; low widens acceptance for unrestricted bytes |
| tx_oh_clk_o | output | 1 | Divided port clock |
| tx_oh_frame_o | output | 1 | Frame marker on the first overhead bit |
| tx_oh_strobe_o | output | 1 | High during each overhead bit slot |
| tx_oh_data_i | input | 1 | Serial overhead data, MSB first |
| tx_oh_ins_i | input | 1 | Per-bit insert request |
| int_byte_i | input | 8 | Internally generated byte for the reported position |
| oh_valid_o | output | 1 | One-cycle pulse per finished byte |
| oh_row_o | output | 4 | Row of the finished byte (0..8) |
| oh_col_o | output | 4 | Column within the tributary (0..8) |
| oh_sts_o | output | 2 | Tributary index (0..2) |
| oh_byte_o | output | 8 | Resulting byte value |
| oh_ext_o | output | 1 | High when the byte came from the serial port |

## Verification
Some properties are checked on every cycle by the assertions. Strobe and marker change only on port-clock rising edges, and the marker never appears without the strobe. Results appear only right after a falling edge, as single-cycle pulses, with positions in range. A last bit that arrives with the request low and software insertion enabled never yields an external byte. Other behaviour can only be shown by the bench's frame scenarios: the walk order, the frame and idle lengths, the per-class acceptance rules over whole frames, partial bytes falling back to the internal value, and the restart after a mid-frame reset.

// File: rtl/toh_port_pkg.sv
package toh_port_pkg;

  parameter int unsigned TOH_ROWS = 9;
  parameter int unsigned TOH_COLS = 9;
  parameter int unsigned TOH_STS  = 3;
  parameter int unsigned BYTE_W   = 8;

  localparam int unsigned ROW_W = $clog2(TOH_ROWS);
  localparam int unsigned COL_W = $clog2(TOH_COLS);
  localparam int unsigned STS_W = $clog2(TOH_STS);
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  typedef struct packed {
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [STS_W-1:0] sts;
  } toh_pos_t;

  // Orderwire, user-channel and data-communication positions: these need an
  // explicit insert request for every bit.
  function automatic logic pos_is_restricted(logic [ROW_W-1:0] row,
                                             logic [COL_W-1:0] col);
    logic hit;
    hit = 1'b0;
    if (row == ROW_W'(1) && col >= COL_W'(3)) hit = 1'b1;
    if (row == ROW_W'(2)) hit = 1'b1;
    if (row >= ROW_W'(5) && row <= ROW_W'(7)) hit = 1'b1;
    if (row == ROW_W'(8) && col >= COL_W'(6)) hit = 1'b1;
    return hit;
  endfunction

endpackage

// File: rtl/toh_portclk.sv
module toh_portclk #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic port_clk_o,
  output logic rise_ce_o,
  output logic fall_ce_o
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pclk_q, pclk_d;
  logic             toggle;

  always_comb begin
    toggle    = (cnt_q == CNT_LAST);
    cnt_d     = toggle ? '0 : cnt_q + CNT_W'(1);
    pclk_d    = toggle ? ~pclk_q : pclk_q;
    rise_ce_o = toggle & ~pclk_q;
    fall_ce_o = toggle &  pclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pclk_q <= pclk_d;
    end
  end

  assign port_clk_o = pclk_q;

endmodule

// File: rtl/toh_walker.sv
module toh_walker
  import toh_port_pkg::*;
#(
  parameter int unsigned IDLE_SLOTS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_ce_i,
  output logic             strobe_o,
  output logic             frame_o,
  output logic [BIT_W-1:0] bit_o,
  output toh_pos_t         pos_o
);

  localparam int unsigned IDLE_W = (IDLE_SLOTS > 1) ? $clog2(IDLE_SLOTS) : 1;
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_SLOTS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(TOH_ROWS - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(TOH_COLS - 1);
  localparam logic [STS_W-1:0]  STS_LAST  = STS_W'(TOH_STS - 1);

  logic              in_toh_q, in_toh_d;
  logic              frame_q, frame_d;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  toh_pos_t          pos_q, pos_d;

  always_comb begin
    in_toh_d = in_toh_q;
    frame_d  = frame_q;
    idle_d   = idle_q;
    bit_d    = bit_q;
    pos_d    = pos_q;
    if (rise_ce_i) begin
      frame_d = 1'b0;
      if (!in_toh_q) begin
        if (idle_q == IDLE_LAST) begin
          in_toh_d = 1'b1;
          frame_d  = 1'b1;
          idle_d   = '0;
          bit_d    = '0;
          pos_d    = '0;
        end else begin
          idle_d = idle_q + IDLE_W'(1);
        end
      end else if (bit_q != BIT_LAST) begin
        bit_d = bit_q + BIT_W'(1);
      end else begin
        bit_d = '0;
        if (pos_q.sts != STS_LAST) begin
          pos_d.sts = pos_q.sts + STS_W'(1);
        end else begin
          pos_d.sts = '0;
          if (pos_q.col != COL_LAST) begin
            pos_d.col = pos_q.col + COL_W'(1);
          end else begin
            pos_d.col = '0;
            if (pos_q.row != ROW_LAST) begin
              pos_d.row = pos_q.row + ROW_W'(1);
            end else begin
              pos_d.row = '0;
              in_toh_d  = 1'b0;
              idle_d    = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_toh_q <= 1'b0;
      frame_q  <= 1'b0;
      idle_q   <= IDLE_LAST;
      bit_q    <= '0;
      pos_q    <= '0;
    end else begin
      in_toh_q <= in_toh_d;
      frame_q  <= frame_d;
      idle_q   <= idle_d;
      bit_q    <= bit_d;
      pos_q    <= pos_d;
    end
  end

  assign strobe_o = in_toh_q;
  assign frame_o  = frame_q;
  assign bit_o    = bit_q;
  assign pos_o    = pos_q;

endmodule

// File: rtl/toh_collector.sv
module toh_collector
  import toh_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_ce_i,
  input  logic              strobe_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  toh_pos_t          pos_i,
  input  logic              data_i,
  input  logic              ins_i,
  input  logic              sw_en_i,
  output logic              valid_o,
  output logic              ext_o,
  output logic [BYTE_W-1:0] byte_o,
  output toh_pos_t          pos_o
);

  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              all_ok_q, all_ok_d;
  logic              valid_q, valid_d;
  logic              ext_q, ext_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  toh_pos_t          opos_q, opos_d;
  logic              restricted;
  logic              take_bit;
  logic              sample;

  always_comb begin
    restricted = pos_is_restricted(pos_i.row, pos_i.col);
    take_bit   = ins_i | (~restricted & ~ins_i & ~sw_en_i);
    sample     = fall_ce_i & strobe_i;

    shift_d  = shift_q;
    all_ok_d = all_ok_q;
    valid_d  = 1'b0;
    ext_d    = ext_q;
    byte_d   = byte_q;
    opos_d   = opos_q;
    if (sample) begin
      shift_d  = {shift_q[BYTE_W-2:0], data_i};
      all_ok_d = ((bit_i == '0) ? 1'b1 : all_ok_q) & take_bit;
      if (bit_i == BIT_LAST) begin
        valid_d = 1'b1;
        ext_d   = all_ok_d;
        byte_d  = shift_d;
        opos_d  = pos_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      all_ok_q <= 1'b0;
      valid_q  <= 1'b0;
      ext_q    <= 1'b0;
      byte_q   <= '0;
      opos_q   <= '0;
    end else begin
      shift_q  <= shift_d;
      all_ok_q <= all_ok_d;
      valid_q  <= valid_d;
      ext_q    <= ext_d;
      byte_q   <= byte_d;
      opos_q   <= opos_d;
    end
  end

  assign valid_o = valid_q;
  assign ext_o   = ext_q;
  assign byte_o  = byte_q;
  assign pos_o   = opos_q;

endmodule

// File: rtl/toh_insert_port.sv
module toh_insert_port
  import toh_port_pkg::*;
#(
  parameter int unsigned HALF_DIV   = 2,
  parameter int unsigned IDLE_SLOTS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_ins_en_i,
  output logic              tx_oh_clk_o,
  output logic              tx_oh_frame_o,
  output logic              tx_oh_strobe_o,
  input  logic              tx_oh_data_i,
  input  logic              tx_oh_ins_i,
  input  logic [BYTE_W-1:0] int_byte_i,
  output logic              oh_valid_o,
  output logic [ROW_W-1:0]  oh_row_o,
  output logic [COL_W-1:0]  oh_col_o,
  output logic [STS_W-1:0]  oh_sts_o,
  output logic [BYTE_W-1:0] oh_byte_o,
  output logic              oh_ext_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              rise_ce, fall_ce;
  logic              strobe;
  logic [BIT_W-1:0]  cur_bit;
  toh_pos_t          cur_pos;
  toh_pos_t          res_pos;
  logic              res_ext;
  logic [BYTE_W-1:0] res_byte;

  toh_portclk #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .port_clk_o (tx_oh_clk_o),
    .rise_ce_o  (rise_ce),
    .fall_ce_o  (fall_ce)
  );

  toh_walker #(.IDLE_SLOTS(IDLE_SLOTS)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .rise_ce_i (rise_ce),
    .strobe_o  (strobe),
    .frame_o   (tx_oh_frame_o),
    .bit_o     (cur_bit),
    .pos_o     (cur_pos)
  );

  toh_collector u_coll (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .fall_ce_i (fall_ce),
    .strobe_i  (strobe),
    .bit_i     (cur_bit),
    .pos_i     (cur_pos),
    .data_i    (tx_oh_data_i),
    .ins_i     (tx_oh_ins_i),
    .sw_en_i   (sw_ins_en_i),
    .valid_o   (oh_valid_o),
    .ext_o     (res_ext),
    .byte_o    (res_byte),
    .pos_o     (res_pos)
  );

  assign tx_oh_strobe_o = strobe;
  assign oh_row_o       = res_pos.row;
  assign oh_col_o       = res_pos.col;
  assign oh_sts_o       = res_pos.sts;
  assign oh_ext_o       = res_ext;
  assign oh_byte_o      = res_ext ? res_byte : int_byte_i;

endmodule

// File: rtl/toh_insert_port_chk.sv
module toh_insert_port_chk
  import toh_port_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sw_ins_en_i,
  input logic             tx_oh_clk_o,
  input logic             tx_oh_frame_o,
  input logic             tx_oh_strobe_o,
  input logic             tx_oh_ins_i,
  input logic             oh_valid_o,
  input logic [ROW_W-1:0] oh_row_o,
  input logic [COL_W-1:0] oh_col_o,
  input logic [STS_W-1:0] oh_sts_o,
  input logic             oh_ext_o
);

  // R1: strobe and marker move only with a rising port clock
  assert_strobe_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tx_oh_strobe_o) |-> $rose(tx_oh_clk_o));
  assert_frame_on_rise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oh_frame_o) |-> $rose(tx_oh_clk_o));

  // R2: the frame marker only sits on a strobe slot
  assert_frame_in_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oh_frame_o |-> tx_oh_strobe_o);

  // R3: reported positions stay inside the grid
  assert_pos_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_valid_o |-> (oh_row_o < ROW_W'(TOH_ROWS)) && (oh_col_o < COL_W'(TOH_COLS))
                   && (oh_sts_o < STS_W'(TOH_STS)));

  // R4: results follow a falling port edge and last one cycle
  assert_valid_after_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_valid_o |-> $fell(tx_oh_clk_o));
  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_valid_o |=> !oh_valid_o);

  // R7: last bit without request while software insertion is on -> internal
  assert_ignored_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oh_valid_o && $past(!tx_oh_ins_i && sw_ins_en_i)) |-> !oh_ext_o);

endmodule

bind toh_insert_port toh_insert_port_chk u_chk (.*);

// File: tb/toh_insert_port_tb.sv
module toh_insert_port_tb;

  localparam int IDLE = 16;
  localparam int BITS_PER_FRAME = 243 * 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_en = 1'b1;
  logic       pclk, frame, strobe;
  logic       tx_data = 1'b0;
  logic       tx_ins = 1'b0;
  logic [7:0] int_byte;
  logic       valid, ext;
  logic [3:0] row, col;
  logic [1:0] sts;
  logic [7:0] obyte;

  always #2.5 clk = ~clk;

  // Internal byte = linear byte index of the reported position
  assign int_byte = 8'((int'(row) * 27 + int'(col) * 3 + int'(sts)) & 255);

  toh_insert_port #(.HALF_DIV(2), .IDLE_SLOTS(IDLE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sw_ins_en_i(sw_en),
    .tx_oh_clk_o(pclk), .tx_oh_frame_o(frame), .tx_oh_strobe_o(strobe),
    .tx_oh_data_i(tx_data), .tx_oh_ins_i(tx_ins), .int_byte_i(int_byte),
    .oh_valid_o(valid), .oh_row_o(row), .oh_col_o(col), .oh_sts_o(sts),
    .oh_byte_o(obyte), .oh_ext_o(ext)
  );

  typedef struct packed {
    logic [3:0] row;
    logic [3:0] col;
    logic [1:0] sts;
    logic       ext;
    logic [7:0] val;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   frame_cnt = 0;
  bit   done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit restricted(int r, int c);
    return (r == 1 && c >= 3) || r == 2 || (r >= 5 && r <= 7) || (r == 8 && c >= 6);
  endfunction

  // Driver: follows the port outputs, drives serial bits, pushes expectations
  int  m_row, m_col, m_sts, m_bit, bitc, idlec, scen;
  bit  first, pend_first, prev_pclk, ok_all;
  initial begin
    first = 1; pend_first = 1; prev_pclk = 0;
    m_row = 0; m_col = 0; m_sts = 0; m_bit = 0; bitc = 0; idlec = 0; scen = 0; ok_all = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        first = 1; pend_first = 1; prev_pclk = 0; bitc = 0; idlec = 0;
        q.delete();
        tx_ins = 0; tx_data = 0;
      end else begin
        bit rise;
        rise = pclk && !prev_pclk;
        prev_pclk = pclk;
        if (rise) begin
          if (pend_first) begin
            chk(frame == 1'b1, "R10", "frame at first edge after reset", int'(frame), 1);
            pend_first = 0;
          end
          if (frame) begin
            if (!first) begin
              chk(bitc == BITS_PER_FRAME, "R2", "strobe cycles per frame", bitc, BITS_PER_FRAME);
              chk(idlec == IDLE, "R2", "idle cycles per frame", idlec, IDLE);
            end
            first = 0;
            frame_cnt++;
            scen = (frame_cnt - 1) % 5;
            sw_en = (scen == 1 || scen == 4) ? 1'b0 : 1'b1;
            m_row = 0; m_col = 0; m_sts = 0; m_bit = 0; bitc = 0; idlec = 0;
          end
          if (strobe) begin
            int  idx;
            bit  ins, acc;
            logic [7:0] dbyte;
            bitc++;
            idx = m_row * 27 + m_col * 3 + m_sts;
            dbyte = 8'(idx) ^ 8'(scen * 8'h3B) ^ 8'hC6;
            case (scen)
              0: ins = 1;
              1: ins = 0;
              2: ins = 0;
              3: ins = !((idx % 5 == 0) && m_bit == 3);
              default: ins = (idx % 2 == 0) ? 1'b1 : (m_bit < 4);
            endcase
            tx_ins  = ins;
            tx_data = dbyte[7 - m_bit];
            // R5 / R6: per-bit acceptance by byte class
            acc = ins || (!restricted(m_row, m_col) && !ins && !sw_en);
            ok_all = (m_bit == 0) ? acc : (ok_all && acc);
            if (m_bit == 7) begin
              exp_t e;
              e.row = 4'(m_row); e.col = 4'(m_col); e.sts = 2'(m_sts);
              e.ext = ok_all;
              e.val = ok_all ? dbyte : 8'(idx);
              q.push_back(e);
              m_bit = 0;
              if (m_sts < 2) m_sts++;
              else begin
                m_sts = 0;
                if (m_col < 8) m_col++;
                else begin m_col = 0; m_row++; end
              end
            end else begin
              m_bit++;
            end
          end else begin
            idlec++;
            tx_ins = 1; tx_data = 1;   // idle slots must produce nothing
          end
        end
      end
    end
  end

  // Monitor: pops and compares each finished byte
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && valid) begin
        if (q.size() == 0) begin
          chk(0, "R4", "result without pending byte", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          // R3 order, R5..R9 value and source
          chk({row, col, sts} == {e.row, e.col, e.sts}, "R3", "position",
              int'({row, col, sts}), int'({e.row, e.col, e.sts}));
          chk(ext == e.ext, e.ext ? "R6" : "R8", "ext flag", int'(ext), int'(e.ext));
          chk(obyte == e.val, "R9", "byte value", int'(obyte), int'(e.val));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // Sequence
  initial begin
    repeat (3) @(negedge clk);
    chk(pclk == 0 && strobe == 0 && frame == 0 && valid == 0, "R10", "reset outputs",
        int'({pclk, strobe, frame, valid}), 0);
    rst_n = 1'b1;
    // frames: all-insert, sw low, ignored, partial drops, mixed
    wait (frame_cnt == 6);
    repeat (1500) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(pclk == 0 && strobe == 0 && frame == 0 && valid == 0, "R10", "mid-frame reset outputs",
        int'({pclk, strobe, frame, valid}), 0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    wait (frame_cnt == 8);
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R4", "all bytes delivered", q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule